// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block sits between a simple single-beat host port and a four-bank SDRAM with a 32-bit data path. Each accepted host request becomes a complete command sequence at the memory pins. The sequence is a row activate, then a column read or write, then a precharge of that one bank. Every row is closed again before the next request is taken, so at most one bank is open at any time. Commands are driven on the chip-select, row-strobe, column-strobe and write-enable lines together with the bank-select and multiplexed address lines. The data bus is split into a driven half with an output-enable and a sampled half.

All spacing rules between commands are held in clock cycles. Each is computed at elaboration from a nanosecond minimum, divided by the clock period and rounded up. After reset the block waits out a power-up idle time. It then issues a precharge of all banks, two auto refreshes and a mode register set, and only after that does it accept requests. A free-running interval counter raises a refresh request. That request wins over a new host request as soon as the current access has finished.

Top module: `sdram_seq`

## Requirements
- R1: After reset no command other than no-op appears for at least ceil(INIT_NS / CLK_PERIOD_NS) cycles. Then come a precharge with address bit 10 high, an auto refresh at least tRP later, a second auto refresh at least tRC later, and a mode set at least tRC later. The mode set carries address word 0x030 (latency 3 in bits 6:4, sequential order, burst of one) and bank 0. `req_ready` stays low until the mode set has been issued.
- R2: The command encodings on {cs_n, ras_n, cas_n, we_n} are: no-op 0111, activate 0011, read 0101, write 0100, precharge 0010, auto refresh 0001, mode set 0000. No other value is ever driven.
- R3: `req_addr[22:21]` is the bank, `req_addr[20:9]` the row and `req_addr[8:0]` the column. An activate drives the bank on `sd_ba` and the row on `sd_addr[11:0]`. A read or write drives the column on `sd_addr[8:0]` with `sd_addr[10]` low.
- R4: A read or write follows its activate by at least ceil(20 ns / period) cycles.
- R5: A single-bank precharge follows its activate by at least ceil(45 ns / period) cycles, and follows a write by at least 2 cycles.
- R6: An activate follows the previous precharge by at least ceil(20 ns / period) cycles, and both the previous activate and the previous auto refresh by at least ceil(65 ns / period) cycles.
- R7: A mode set or auto refresh is issued only while no bank is open. No command other than no-op appears within 2 cycles after a mode set.
- R8: A refresh request is raised every floor(REFI_NS / period) cycles. It takes priority over a waiting host request once the running access has closed its row, so two refreshes are never more than the interval plus one access apart.
- R9: For a read, `rd_valid` pulses for one cycle. `rd_data` holds the value on `sd_dq_in` sampled at the edge CAS_LAT cycles after the edge at which the memory takes the read command, and `rd_valid` is visible in the cycle after that edge.
- R10: The write data appears on `sd_dq_out`, with `sd_dq_oe` high, in the cycle of the write command and only then. `wr_ack` pulses in that same cycle.
- R11: Every access closes its row with a precharge of the same bank with `sd_addr[10]` low, and no activate is issued while a row is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Bank, row, column of the access |
| req_wdata | input | 32 | Write data, taken with the request |
| req_ready | output | 1 | Request accepted at this edge when high with req_valid |
| wr_ack | output | 1 | Write data is on the memory bus this cycle |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 32 | Read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Multiplexed row/column address |
| sd_dq_out | output | 32 | Data driven toward the memory |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | 32 | Data returned by the memory |

## Verification
A wrong state or timer value in the sequencer shows up at the command pins straight away. A command then arrives a cycle early, out of order, or against the wrong bank or row, and the pin monitor catches it the same cycle. Address or data path faults are caught a few cycles later. The bench keeps a memory model keyed by the bank, row and column actually driven, so a misplaced write surfaces as a wrong value on the next read of that location. A broken refresh counter or priority rule is detected when the gap between refreshes grows past one interval plus one access.

// File: rtl/sdram_seq.sv
module sdram_seq #(
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_RRD_NS      = 15,
  parameter int T_RCD_NS      = 20,
  parameter int T_RP_NS       = 20,
  parameter int T_RAS_NS      = 45,
  parameter int T_RC_NS       = 65,
  parameter int REFI_NS       = 7800,
  parameter int INIT_NS       = 2000,
  parameter int CAS_LAT       = 3,
  parameter int WR_RECOV_CLK  = 2,
  parameter int MRS_GAP_CLK   = 2,
  parameter int BANK_W        = 2,
  parameter int ROW_W         = 12,
  parameter int COL_W         = 9,
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = BANK_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              wr_ack,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [DATA_W-1:0] sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_in
);

  function automatic int ns2clk(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RRD_C      = ns2clk(T_RRD_NS);
  localparam int RCD_C      = ns2clk(T_RCD_NS);
  localparam int RP_C       = ns2clk(T_RP_NS);
  localparam int RAS_C      = ns2clk(T_RAS_NS);
  localparam int RC_C       = ns2clk(T_RC_NS);
  localparam int INIT_C     = ns2clk(INIT_NS);
  localparam int REFI_C     = imax(REFI_NS / CLK_PERIOD_NS, 2);
  localparam int RW2PRE_RD  = imax(RAS_C - RCD_C, 1);
  localparam int RW2PRE_WR  = imax(RAS_C - RCD_C, WR_RECOV_CLK);
  localparam int PRE2ACT_RD = imax(imax(RP_C, RRD_C), RC_C - RCD_C - RW2PRE_RD);
  localparam int PRE2ACT_WR = imax(imax(RP_C, RRD_C), RC_C - RCD_C - RW2PRE_WR);
  localparam int TMR_W      = $clog2(imax(INIT_C, RC_C) + 1) + 1;
  localparam int REF_W      = $clog2(REFI_C + 1);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);
  localparam logic [ROW_W-1:0] ALL_BANKS = ROW_W'(1 << 10);

  typedef enum logic [2:0] {
    S_INIT, S_REF1, S_REF2, S_MRS, S_IDLE, S_RW, S_PRE
  } state_t;

  state_t            state;
  logic [TMR_W-1:0]  tmr;
  logic [3:0]        cmd_q;
  logic              lat_wr;
  logic [BANK_W-1:0] lat_bank;
  logic [COL_W-1:0]  lat_col;
  logic [DATA_W-1:0] lat_data;
  logic [REF_W-1:0]  ref_cnt;
  logic              ref_pend;
  logic [CAS_LAT:0]  rd_pipe;
  logic              slot_free;
  logic              ref_go;
  logic              rd_go;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign slot_free = (tmr == '0);
  assign ref_go    = slot_free && (state == S_IDLE) && ref_pend;
  assign req_ready = slot_free && (state == S_IDLE) && !ref_pend;
  assign rd_go     = slot_free && (state == S_RW) && !lat_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_INIT;
      tmr       <= TMR_W'(INIT_C - 1);
      cmd_q     <= C_NOP;
      sd_ba     <= '0;
      sd_addr   <= '0;
      sd_dq_out <= '0;
      sd_dq_oe  <= 1'b0;
      wr_ack    <= 1'b0;
      lat_wr    <= 1'b0;
      lat_bank  <= '0;
      lat_col   <= '0;
      lat_data  <= '0;
    end else begin
      cmd_q    <= C_NOP;
      sd_dq_oe <= 1'b0;
      wr_ack   <= 1'b0;
      if (!slot_free) begin
        tmr <= tmr - 1'b1;
      end else begin
        case (state)
          S_INIT: begin
            cmd_q   <= C_PRE;
            sd_addr <= ALL_BANKS;
            tmr     <= TMR_W'(RP_C - 1);
            state   <= S_REF1;
          end
          S_REF1: begin
            cmd_q <= C_REF;
            tmr   <= TMR_W'(RC_C - 1);
            state <= S_REF2;
          end
          S_REF2: begin
            cmd_q <= C_REF;
            tmr   <= TMR_W'(RC_C - 1);
            state <= S_MRS;
          end
          S_MRS: begin
            cmd_q   <= C_MRS;
            sd_ba   <= '0;
            sd_addr <= MODE_WORD;
            tmr     <= TMR_W'(MRS_GAP_CLK - 1);
            state   <= S_IDLE;
          end
          S_IDLE: begin
            if (ref_pend) begin
              cmd_q <= C_REF;
              tmr   <= TMR_W'(RC_C - 1);
            end else if (req_valid) begin
              cmd_q    <= C_ACT;
              sd_ba    <= req_addr[ADDR_W-1 -: BANK_W];
              sd_addr  <= req_addr[COL_W +: ROW_W];
              lat_wr   <= req_write;
              lat_bank <= req_addr[ADDR_W-1 -: BANK_W];
              lat_col  <= req_addr[COL_W-1:0];
              lat_data <= req_wdata;
              tmr      <= TMR_W'(RCD_C - 1);
              state    <= S_RW;
            end
          end
          S_RW: begin
            cmd_q   <= lat_wr ? C_WR : C_RD;
            sd_ba   <= lat_bank;
            sd_addr <= ROW_W'(lat_col);
            if (lat_wr) begin
              sd_dq_out <= lat_data;
              sd_dq_oe  <= 1'b1;
              wr_ack    <= 1'b1;
              tmr       <= TMR_W'(RW2PRE_WR - 1);
            end else begin
              tmr <= TMR_W'(RW2PRE_RD - 1);
            end
            state <= S_PRE;
          end
          S_PRE: begin
            cmd_q   <= C_PRE;
            sd_ba   <= lat_bank;
            sd_addr <= '0;
            tmr     <= lat_wr ? TMR_W'(PRE2ACT_WR - 1) : TMR_W'(PRE2ACT_RD - 1);
            state   <= S_IDLE;
          end
          default: state <= S_INIT;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt  <= '0;
      ref_pend <= 1'b0;
    end else begin
      if (ref_go) ref_pend <= 1'b0;
      if (ref_cnt == REF_W'(REFI_C - 1)) begin
        ref_cnt  <= '0;
        ref_pend <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pipe  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_pipe  <= {rd_pipe[CAS_LAT-1:0], rd_go};
      rd_valid <= rd_pipe[CAS_LAT];
      if (rd_pipe[CAS_LAT]) rd_data <= sd_dq_in;
    end
  end

endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
  parameter int RCD     = 5,
  parameter int RP      = 5,
  parameter int RAS     = 12,
  parameter int RC      = 17,
  parameter int WRREC   = 2,
  parameter int MRS_GAP = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cmd,
  input logic       a10,
  input logic       req_ready,
  input logic       dq_oe
);

  localparam logic [3:0] K_NOP = 4'b0111;
  localparam logic [3:0] K_ACT = 4'b0011;
  localparam logic [3:0] K_RD  = 4'b0101;
  localparam logic [3:0] K_WR  = 4'b0100;
  localparam logic [3:0] K_PRE = 4'b0010;
  localparam logic [3:0] K_REF = 4'b0001;
  localparam logic [3:0] K_MRS = 4'b0000;
  localparam int SAT = 1000;

  int   s_act, s_pre, s_wr, s_ref, s_mrs;
  logic open_q, mrs_seen;

  function automatic int bump(input int v);
    return (v >= SAT) ? SAT : v + 1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_act    <= SAT;
      s_pre    <= SAT;
      s_wr     <= SAT;
      s_ref    <= SAT;
      s_mrs    <= SAT;
      open_q   <= 1'b0;
      mrs_seen <= 1'b0;
    end else begin
      s_act <= (cmd == K_ACT) ? 1 : bump(s_act);
      s_pre <= (cmd == K_PRE) ? 1 : bump(s_pre);
      s_wr  <= (cmd == K_WR)  ? 1 : bump(s_wr);
      s_ref <= (cmd == K_REF) ? 1 : bump(s_ref);
      s_mrs <= (cmd == K_MRS) ? 1 : bump(s_mrs);
      if (cmd == K_ACT) open_q <= 1'b1;
      else if (cmd == K_PRE) open_q <= 1'b0;
      if (cmd == K_MRS) mrs_seen <= 1'b1;
    end
  end

  AST_READY_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mrs_seen); // R1
  AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_RD || cmd == K_WR) |-> s_act >= RCD); // R4
  AST_RAS_WR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_PRE && !a10) |-> (s_act >= RAS && s_wr >= WRREC)); // R5
  AST_RP_RC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_ACT) |-> (s_pre >= RP && s_act >= RC && s_ref >= RC)); // R6
  AST_IDLE_BEFORE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_MRS || cmd == K_REF) |-> !open_q); // R7
  AST_MRS_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != K_NOP) |-> s_mrs >= MRS_GAP); // R7
  AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> cmd == K_WR); // R10
  AST_SINGLE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_ACT) |-> !open_q); // R11

endmodule

bind sdram_seq sdram_seq_chk #(
  .RCD(RCD_C), .RP(RP_C), .RAS(RAS_C), .RC(RC_C),
  .WRREC(WR_RECOV_CLK), .MRS_GAP(MRS_GAP_CLK)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .cmd({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
  .a10(sd_addr[10]),
  .req_ready(req_ready),
  .dq_oe(sd_dq_oe)
);

// File: tb/tb_sdram_seq.sv
module tb_sdram_seq;
  localparam int P     = 4;
  localparam int CL    = 3;
  localparam int RCD   = (20 + P - 1) / P;
  localparam int RP    = (20 + P - 1) / P;
  localparam int RAS   = (45 + P - 1) / P;
  localparam int RC    = (65 + P - 1) / P;
  localparam int INITC = (2000 + P - 1) / P;
  localparam int REFI  = 7800 / P;

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_MRS = 4'b0000;

  typedef struct {
    bit          wr;
    logic [22:0] a;
    logic [31:0] d;
  } req_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [22:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, wr_ack, rd_valid;
  logic [31:0] rd_data;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0]  sd_ba;
  logic [11:0] sd_addr;
  logic [31:0] sd_dq_out;
  logic [31:0] sd_dq_in = 32'hA5A5_5A5A;

  sdram_seq dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .wr_ack(wr_ack),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in)
  );

  int vectors = 0, errors = 0;
  req_t        acc_q[$];
  logic [31:0] exp_rd[$];
  logic [31:0] shadow[logic [22:0]];
  logic [31:0] mem[logic [22:0]];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic serve_read(input logic [31:0] v);
    repeat (CL) @(negedge clk);
    sd_dq_in = v;
    @(negedge clk);
    sd_dq_in = 32'hA5A5_5A5A;
  endtask

  int cyc = 0, ninit = 0, nref = 0;
  int last_act = -1000, last_pre = -1000, last_ref = -1000, last_wr = -1000;
  int last_mrs = -1000, last_rd = -1000;
  bit open = 0, early_rdy = 0;
  logic [1:0]  obank;
  logic [11:0] orow;
  req_t        cur;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] c;
      cyc++;
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (ninit < 4 && req_ready) early_rdy = 1;
      if (sd_dq_oe && c != C_WR) chk(0, "R10", "dq_oe outside write", c, C_WR);
      if (c != C_NOP && ninit == 4) chk(cyc - last_mrs >= 2, "R7", "gap after mode set", cyc - last_mrs, 2);
      case (c)
        C_NOP: ;
        C_PRE: begin
          if (ninit == 0) begin
            chk(sd_addr[10], "R1", "init precharge all A10", sd_addr[10], 1);
            chk(cyc >= INITC, "R1", "power-up idle cycles", cyc, INITC);
            ninit = 1;
          end else begin
            chk(!sd_addr[10], "R11", "single bank precharge A10", sd_addr[10], 0);
            chk(open && sd_ba == obank, "R11", "precharge bank", sd_ba, obank);
            chk(cyc - last_act >= RAS, "R5", "act to precharge", cyc - last_act, RAS);
            if (cur.wr) chk(cyc - last_wr >= 2, "R5", "write to precharge", cyc - last_wr, 2);
            open = 0;
          end
          last_pre = cyc;
        end
        C_REF: begin
          if (ninit == 1) begin
            chk(cyc - last_pre >= RP, "R1", "precharge to refresh", cyc - last_pre, RP);
            ninit = 2;
          end else if (ninit == 2) begin
            chk(cyc - last_ref >= RC, "R1", "refresh to refresh", cyc - last_ref, RC);
            ninit = 3;
          end else begin
            chk(ninit == 4 && !open, "R7", "refresh with row open", open, 0);
            chk(cyc - last_ref <= REFI + 40, "R8", "refresh interval", cyc - last_ref, REFI + 40);
            nref++;
          end
          last_ref = cyc;
        end
        C_MRS: begin
          chk(ninit == 3 && !open, "R1", "mode set order", ninit, 3);
          chk(sd_addr == 12'h030 && sd_ba == 2'b00, "R1", "mode word", {sd_ba, sd_addr}, 12'h030);
          chk(cyc - last_ref >= RC, "R1", "refresh to mode set", cyc - last_ref, RC);
          ninit = 4;
          last_mrs = cyc;
        end
        C_ACT: begin
          chk(!open, "R11", "activate with row open", open, 0);
          chk(cyc - last_pre >= RP, "R6", "precharge to act", cyc - last_pre, RP);
          chk(cyc - last_act >= RC && cyc - last_ref >= RC, "R6", "act/ref to act",
              (cyc - last_act < cyc - last_ref) ? cyc - last_act : cyc - last_ref, RC);
          if (acc_q.size() == 0) chk(0, "R3", "activate with no request", 1, 0);
          else begin
            cur = acc_q.pop_front();
            chk(sd_ba == cur.a[22:21] && sd_addr == cur.a[20:9], "R3", "bank/row",
                {sd_ba, sd_addr}, cur.a[22:9]);
          end
          open = 1; obank = sd_ba; orow = sd_addr; last_act = cyc;
        end
        C_RD, C_WR: begin
          chk(open && sd_ba == obank, "R3", "column bank", sd_ba, obank);
          chk(sd_addr[8:0] == cur.a[8:0] && !sd_addr[10], "R3", "column address", sd_addr, cur.a[8:0]);
          chk(cyc - last_act >= RCD, "R4", "act to column", cyc - last_act, RCD);
          if (c == C_WR) begin
            chk(sd_dq_oe && sd_dq_out == cur.d, "R10", "write data", sd_dq_out, cur.d);
            chk(wr_ack, "R10", "write ack", wr_ack, 1);
            mem[{sd_ba, orow, sd_addr[8:0]}] = sd_dq_out;
            last_wr = cyc;
          end else begin
            logic [22:0] k;
            k = {sd_ba, orow, sd_addr[8:0]};
            fork serve_read(mem.exists(k) ? mem[k] : 32'hFFFF_FFFF); join_none
            last_rd = cyc;
          end
        end
        default: chk(0, "R2", "illegal command code", c, C_NOP);
      endcase
      if (rd_valid) begin
        chk(cyc == last_rd + CL + 1, "R9", "read data timing", cyc - last_rd, CL + 1);
        if (exp_rd.size() == 0) chk(0, "R9", "unexpected read data", rd_data, 0);
        else begin
          logic [31:0] e;
          e = exp_rd.pop_front();
          chk(rd_data == e, "R9", "read data", rd_data, e);
        end
      end
    end
  end

  task automatic access(input bit w, input logic [22:0] a, input logic [31:0] d);
    req_t r;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    r.wr = w; r.a = a; r.d = d;
    acc_q.push_back(r);
    if (w) shadow[a] = d;
    else exp_rd.push_back(shadow.exists(a) ? shadow[a] : 32'hFFFF_FFFF);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R1", "watchdog expired", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!req_ready && !rd_valid && !wr_ack, "R1", "reset outputs", {req_ready, rd_valid, wr_ack}, 0);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP && !sd_dq_oe, "R2", "reset command",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    rst_n = 1'b1;
    @(negedge clk);
    access(1, {2'd0, 12'h000, 9'h000}, 32'h1111_1111);
    access(1, {2'd1, 12'h005, 9'h007}, 32'h2222_2222);
    access(1, {2'd2, 12'hFFF, 9'h1FF}, 32'hDEAD_BEEF);
    access(1, {2'd3, 12'h000, 9'h1FF}, 32'h0000_0001);
    access(1, {2'd0, 12'h001, 9'h000}, 32'h8000_0000);
    access(0, {2'd0, 12'h000, 9'h000}, 0);
    access(0, {2'd1, 12'h005, 9'h007}, 0);
    access(0, {2'd2, 12'hFFF, 9'h1FF}, 0);
    access(0, {2'd3, 12'h000, 9'h1FF}, 0);
    access(0, {2'd0, 12'h001, 9'h000}, 0);
    access(0, {2'd3, 12'h123, 9'h045}, 0);
    access(1, {2'd2, 12'hFFF, 9'h1FF}, 32'h0BAD_F00D);
    access(0, {2'd2, 12'hFFF, 9'h1FF}, 0);
    access(0, {2'd2, 12'hFFF, 9'h1FF}, 0);
    for (int i = 0; i < 220; i++) begin
      logic [22:0] a;
      a = {2'($urandom), 12'($urandom % 4), 9'($urandom % 8)};
      access(1'($urandom), a, $urandom);
    end
    repeat (2 * REFI + 20) @(negedge clk);
    chk(exp_rd.size() == 0, "R9", "reads left unanswered", exp_rd.size(), 0);
    chk(acc_q.size() == 0, "R11", "requests never activated", acc_q.size(), 0);
    chk(!early_rdy, "R1", "ready before mode set", early_rdy, 0);
    chk(ninit == 4, "R1", "init sequence steps", ninit, 4);
    chk(nref >= cyc / REFI - 1, "R8", "refresh count", nref, cyc / REFI - 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule